// File: doc/BRIEF.md
# Bus Bit Monitor with Arbitration Resolution

This block sits beside the transmit path of a node on a wired-AND serial bus. In such a bus a dominant level (logic 0) overrides a recessive level (logic 1). At every sample point it compares the bit the node is driving with the bit it reads back from the bus. The framer tells it which part of the frame is active: the identifier arbitration phase, the acknowledge slot, a passive error flag, or any other field.

The same mismatch means different things depending on the field. In the arbitration phase, sending recessive and reading dominant means the node has lost arbitration. The block then forces the driven bit to recessive for the rest of the frame and tells the transmitter to act as a receiver. In the acknowledge slot and during a passive error flag, that same mismatch is expected and raises nothing. In every other field, any mismatch is a bit error. If the transmitter sends recessive in the acknowledge slot and still reads recessive, it reports an acknowledge error. A data frame and a remote frame with the same identifier resolve in favour of the data frame, because the data frame's request bit is dominant and so wins arbitration.

The result pulses appear one clock after the sample strobe. The release flag persists until the framer signals that the frame is idle.

Top module: `bus_bit_monitor`

## Requirements
- R1: After reset, arb_lost, bit_err, ack_err and release_bus are 0, and drive_bit follows tx_bit.
- R2: With field_sel=2'b01 (arbitration), tx_active=1 and sample_en=1, tx_bit=1 read back as bus_bit=0 gives a one-cycle arb_lost pulse on the next clock, sets release_bus, and raises no bit_err. This also covers the case where a remote frame's recessive request bit loses to a data frame's dominant one.
- R3: While release_bus is 1, drive_bit is 1 (recessive) whatever tx_bit is.
- R4: frame_idle=1 at a clock edge clears release_bus on that edge.
- R5: With field_sel=2'b00 (other field), any difference between tx_bit and bus_bit on a strobe gives a bit_err pulse on the next clock.
- R6: With field_sel=2'b10 (acknowledge slot), tx_bit=1 and bus_bit=0 raises nothing; tx_bit=1 and bus_bit=1 gives an ack_err pulse on the next clock.
- R7: With field_sel=2'b11 (passive error flag), reading a dominant bus_bit raises no error.
- R8: In every field, tx_bit=0 read back as bus_bit=1 gives a bit_err pulse on the next clock.
- R9: No pulse follows a clock where sample_en=0 or tx_active=0.
- R10: While release_bus is 1, strobes produce no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Sample-point strobe, one clock wide |
| tx_active | input | 1 | Node is currently the transmitter |
| field_sel | input | 2 | 00 other, 01 arbitration, 10 ack slot, 11 passive error flag |
| tx_bit | input | 1 | Bit the transmitter wants to send |
| bus_bit | input | 1 | Bus level sampled at the sample point |
| frame_idle | input | 1 | Frame finished; clears the release state |
| drive_bit | output | 1 | Level actually driven toward the bus |
| arb_lost | output | 1 | Pulse: arbitration lost |
| bit_err | output | 1 | Pulse: bit error |
| ack_err | output | 1 | Pulse: acknowledge error |
| release_bus | output | 1 | Transmitter must release the bus and receive |

## Verification
The block has a single piece of state, the release flag. If that flag is wrong, it shows on drive_bit in the same cycle. A flag stuck high forces recessive on every bit. A flag that is never set leaves a losing node still driving dominant bits. A wrong flag also shows one clock later as missing or extra pulses on the next strobe. A wrong field decode shows as a pulse on the wrong output in the clock after the strobe. For that reason the bench sweeps every combination of field, sent bit, read bit, strobe and transmitter role, and starts each combination from a known release state.

// File: rtl/bus_bit_monitor.sv
module bus_bit_monitor (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_en,
  input  logic       tx_active,
  input  logic [1:0] field_sel,
  input  logic       tx_bit,
  input  logic       bus_bit,
  input  logic       frame_idle,
  output logic       drive_bit,
  output logic       arb_lost,
  output logic       bit_err,
  output logic       ack_err,
  output logic       release_bus
);

  localparam logic [1:0] FLD_OTHER = 2'b00;
  localparam logic [1:0] FLD_ARB   = 2'b01;
  localparam logic [1:0] FLD_ACK   = 2'b10;
  localparam logic [1:0] FLD_PFLAG = 2'b11;

  logic live, rec_seen_dom, dom_seen_rec;
  logic lose_nx, berr_nx, aerr_nx;

  assign live         = sample_en & tx_active & ~release_bus;
  assign rec_seen_dom = tx_bit & ~bus_bit;
  assign dom_seen_rec = ~tx_bit & bus_bit;

  assign lose_nx = live & (field_sel == FLD_ARB) & rec_seen_dom;
  assign aerr_nx = live & (field_sel == FLD_ACK) & tx_bit & bus_bit;
  assign berr_nx = live & (dom_seen_rec | (rec_seen_dom & (field_sel == FLD_OTHER)));

  assign drive_bit = release_bus | tx_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_lost    <= 1'b0;
      bit_err     <= 1'b0;
      ack_err     <= 1'b0;
      release_bus <= 1'b0;
    end else begin
      arb_lost    <= lose_nx;
      bit_err     <= berr_nx;
      ack_err     <= aerr_nx;
      release_bus <= frame_idle ? 1'b0 : (release_bus | lose_nx);
    end
  end

  AST_LOST_NOT_BITERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(arb_lost && bit_err)); // R2
  AST_LOST_HOLDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> release_bus); // R2
  AST_RELEASED_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    release_bus |-> drive_bit); // R3
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_idle |=> !release_bus); // R4
  AST_NO_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_en || !tx_active) |=> !(arb_lost || bit_err || ack_err)); // R9
  AST_RELEASED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    release_bus |=> !(arb_lost || bit_err || ack_err)); // R10
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arb_lost, bit_err, ack_err})); // R9
  AST_PFLAG_DOM_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && field_sel == FLD_PFLAG && !bus_bit) |=> !bit_err); // R7

endmodule

// File: tb/bus_bit_monitor_tb_top.sv
module bus_bit_monitor_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_en = 1'b0, tx_active = 1'b0, tx_bit = 1'b1, bus_bit = 1'b1, frame_idle = 1'b0;
  logic [1:0] field_sel = 2'b00;
  logic drive_bit, arb_lost, bit_err, ack_err, release_bus;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_bit_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .tx_active(tx_active),
    .field_sel(field_sel), .tx_bit(tx_bit), .bus_bit(bus_bit), .frame_idle(frame_idle),
    .drive_bit(drive_bit), .arb_lost(arb_lost), .bit_err(bit_err), .ack_err(ack_err),
    .release_bus(release_bus));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic clear_release();
    @(negedge clk); frame_idle = 1'b1; sample_en = 1'b0;
    @(negedge clk); frame_idle = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R1 arb_lost", arb_lost, 1'b0);
    chk("R1 bit_err", bit_err, 1'b0);
    chk("R1 ack_err", ack_err, 1'b0);
    chk("R1 release_bus", release_bus, 1'b0);
    tx_bit = 1'b0; #0;
    chk("R1 drive_bit", drive_bit, 1'b0);
    rst_n = 1'b1;

    for (int c = 0; c < 64; c++) begin
      logic [1:0] f; logic t, b, act, en;
      logic e_lost, e_berr, e_aerr;
      f = c[1:0]; t = c[2]; b = c[3]; act = c[4]; en = c[5];
      clear_release();
      field_sel = f; tx_bit = t; bus_bit = b; tx_active = act; sample_en = en;
      e_lost = en && act && f == 2'd1 && t && !b;
      e_aerr = en && act && f == 2'd2 && t && b;
      e_berr = en && act && ((!t && b) || (f == 2'd0 && t && !b));
      @(negedge clk);
      sample_en = 1'b0;
      chk("R2 arb_lost sweep", arb_lost, e_lost);
      chk("R5/R7/R8/R9 bit_err sweep", bit_err, e_berr);
      chk("R6 ack_err sweep", ack_err, e_aerr);
      chk("R2 release_bus sweep", release_bus, e_lost);
      tx_bit = 1'b0; #0;
      chk("R3 drive_bit sweep", drive_bit, e_lost);
    end

    clear_release();
    field_sel = 2'd1; tx_active = 1'b1; tx_bit = 1'b1; bus_bit = 1'b0; sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
    chk("R2 remote request bit loses", arb_lost, 1'b1);
    field_sel = 2'd0; tx_bit = 1'b0; bus_bit = 1'b1; sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
    chk("R10 no bit_err while released", bit_err, 1'b0);
    chk("R3 still released", release_bus, 1'b1);
    chk("R3 drive recessive", drive_bit, 1'b1);
    frame_idle = 1'b1;
    @(negedge clk);
    frame_idle = 1'b0;
    chk("R4 idle clears release", release_bus, 1'b0);
    chk("R4 drive follows tx_bit", drive_bit, 1'b0);
    sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
    chk("R5 bit_err after idle", bit_err, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule